// File: doc/BRIEF.md
# Privilege and Special-Register Exception Classifier

This block sits beside the instruction decoder of a small RISC core. For each issued instruction it takes the decoded instruction class, a 10-bit special-register number and a trap-condition flag. It returns one registered 3-bit result code. The code says whether the instruction proceeds normally, turns into a silent no-op, or raises one of four exceptions: illegal instruction, privileged instruction, system call or trap. Fetch, full decode, address-translation faults, floating-point faults and handler entry are handled elsewhere.

Special-register accesses are checked against a parameterised table. Each table entry holds a register number, a valid flag, a supervisor-only flag and a read-only flag. The block also holds the user-mode bit. A write to the machine-state register first fills a pending copy. That copy becomes the active mode only when a context-synchronising instruction is issued, so every instruction in between is checked against the old mode.

Top module: `instr_priv_checker`

## Requirements
- R1: During and after reset, resultValid is 0, resultCode is 0 and userMode equals the reset parameter (default 0, supervisor).
- R2: An instruction presented with issueValid high at a clock edge gives resultValid high after that edge, for exactly one cycle. With issueValid low, resultValid is low after the edge. resultCode values are: 0 none, 1 illegal instruction, 2 privileged instruction, 3 system call, 4 trap, 5 no-op. Class 0 (ordinary instruction) and class 16 (context synchronise) give code 0.
- R3: The fixed supervisor-only classes are 1 cache-block invalidate, 2 read machine state, 3 write machine state, 4 read segment, 5 write segment, 6 read segment indexed, 7 write segment indexed, 8 return from exception, 9 TLB entry invalidate and 10 TLB synchronise. Each gives code 2 when userMode is 1 and code 0 when userMode is 0.
- R4: Class 11 (write special register), 12 (read special register) or 13 (read time base) gives code 1 in either mode when the register number matches no table entry, or matches only an entry whose valid flag is clear. This takes priority over codes 2 and 5.
- R5: For a valid entry, classes 11 to 13 give code 2 when the entry is supervisor-only and userMode is 1. Otherwise they give code 0, unless R6 applies.
- R6: Class 11 aimed at a valid read-only entry whose access is permitted gives code 5 instead of an exception.
- R7: Class 14 (system call) gives code 3 in either mode.
- R8: Class 15 (trap) gives code 4 when trapCond is 1 and code 0 when it is 0.
- R9: Class 3 in supervisor mode stores msrWrData as the pending mode and leaves userMode unchanged. userMode takes the pending value only after a class 16 instruction, and changes at no other time.
- R10: Class 3 issued in user mode leaves the pending mode unchanged, so a later class 16 keeps userMode at 1.
- R11: Class codes 17 to 31 give code 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | An instruction is presented this cycle |
| instrClass | input | 5 | Decoded instruction class |
| sprNum | input | 10 | Special-register or time-base number |
| trapCond | input | 1 | Trap condition evaluated true |
| msrWrData | input | 1 | User-mode bit carried by a machine-state write |
| resultValid | output | 1 | Result for the previous cycle's instruction |
| resultCode | output | 3 | Classification code |
| userMode | output | 1 | Active user-mode bit used for checks |

## Verification
The properties assume that instrClass, trapCond and sprNum are defined whenever issueValid is high, and that only one instruction is issued per cycle. The properties also assume that userMode moves only in response to the inputs. The stimulus drives every input at the falling edge. It issues every one of the 32 class codes in both modes, against each table number, the invalid entry and several unimplemented numbers, with trapCond at both values. msrWrData is held equal to the current mode during the sweeps, so the mode changes only in the dedicated sequences.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  localparam int CLASS_W = 5;
  localparam int SPR_W   = 10;
  localparam int CODE_W  = 3;

  typedef enum logic [CLASS_W-1:0] {
    CL_PLAIN     = 5'd0,
    CL_CACHEINV  = 5'd1,
    CL_RDSTATE   = 5'd2,
    CL_WRSTATE   = 5'd3,
    CL_RDSEG     = 5'd4,
    CL_WRSEG     = 5'd5,
    CL_RDSEGX    = 5'd6,
    CL_WRSEGX    = 5'd7,
    CL_EXCRET    = 5'd8,
    CL_TLBINV    = 5'd9,
    CL_TLBSYNC   = 5'd10,
    CL_WRSPECIAL = 5'd11,
    CL_RDSPECIAL = 5'd12,
    CL_RDTIME    = 5'd13,
    CL_SYSCALL   = 5'd14,
    CL_TRAP      = 5'd15,
    CL_CTXSYNC   = 5'd16
  } instrClass_e;

  typedef enum logic [CODE_W-1:0] {
    RES_NONE    = 3'd0,
    RES_ILLEGAL = 3'd1,
    RES_PRIV    = 3'd2,
    RES_SYSCALL = 3'd3,
    RES_TRAP    = 3'd4,
    RES_NOP     = 3'd5
  } resCode_e;

  typedef struct packed {
    logic [SPR_W-1:0] num;
    logic             valid;
    logic             supv;
    logic             ro;
  } sprEntry_t;

  typedef struct packed {
    logic              capture;
    logic [CODE_W-1:0] code;
    logic              loadPending;
    logic              commitMode;
  } ctrlStrobe_t;

  localparam int DEF_SPR_COUNT = 11;
  localparam sprEntry_t [DEF_SPR_COUNT-1:0] DEF_SPR_TABLE = '{
    '{num: 10'd1,    valid: 1'b1, supv: 1'b0, ro: 1'b0},
    '{num: 10'd8,    valid: 1'b1, supv: 1'b0, ro: 1'b0},
    '{num: 10'd9,    valid: 1'b1, supv: 1'b0, ro: 1'b0},
    '{num: 10'd26,   valid: 1'b1, supv: 1'b1, ro: 1'b0},
    '{num: 10'd272,  valid: 1'b1, supv: 1'b1, ro: 1'b0},
    '{num: 10'd268,  valid: 1'b1, supv: 1'b0, ro: 1'b1},
    '{num: 10'd269,  valid: 1'b1, supv: 1'b0, ro: 1'b1},
    '{num: 10'd287,  valid: 1'b1, supv: 1'b1, ro: 1'b1},
    '{num: 10'd1008, valid: 1'b1, supv: 1'b1, ro: 1'b0},
    '{num: 10'd1009, valid: 1'b1, supv: 1'b1, ro: 1'b1},
    '{num: 10'd1013, valid: 1'b0, supv: 1'b1, ro: 1'b0}
  };
endpackage

// File: rtl/ipc_ctrl.sv
module ipc_ctrl
  import ipc_pkg::*;
(
  input  logic               issueValid,
  input  logic [CLASS_W-1:0] instrClass,
  input  logic               trapCond,
  input  logic               curUser,
  input  logic               sprHit,
  input  logic               sprSupv,
  input  logic               sprRo,
  output ctrlStrobe_t        strobe
);
  localparam logic [CLASS_W-1:0] LAST_CLASS = CL_CTXSYNC;

  resCode_e code;
  logic     loadPending;
  logic     commitMode;

  always_comb begin
    code        = RES_NONE;
    loadPending = 1'b0;
    commitMode  = 1'b0;
    if (issueValid) begin
      if (instrClass > LAST_CLASS) begin
        code = RES_ILLEGAL;
      end else begin
        case (instrClass_e'(instrClass))
          CL_WRSPECIAL, CL_RDSPECIAL, CL_RDTIME: begin
            if (!sprHit)
              code = RES_ILLEGAL;
            else if (sprSupv && curUser)
              code = RES_PRIV;
            else if ((instrClass == CL_WRSPECIAL) && sprRo)
              code = RES_NOP;
          end
          CL_WRSTATE: begin
            if (curUser) code = RES_PRIV;
            else         loadPending = 1'b1;
          end
          CL_CACHEINV, CL_RDSTATE, CL_RDSEG, CL_WRSEG, CL_RDSEGX,
          CL_WRSEGX, CL_EXCRET, CL_TLBINV, CL_TLBSYNC: begin
            if (curUser) code = RES_PRIV;
          end
          CL_SYSCALL: code = RES_SYSCALL;
          CL_TRAP:    if (trapCond) code = RES_TRAP;
          CL_CTXSYNC: commitMode = 1'b1;
          default:    code = RES_NONE;
        endcase
      end
    end
  end

  always_comb begin
    strobe.capture     = issueValid;
    strobe.code        = code;
    strobe.loadPending = loadPending;
    strobe.commitMode  = commitMode;
  end
endmodule

// File: rtl/ipc_dpath.sv
module ipc_dpath
  import ipc_pkg::*;
#(
  parameter int                          SPR_COUNT     = DEF_SPR_COUNT,
  parameter sprEntry_t [SPR_COUNT-1:0]   SPR_TABLE     = DEF_SPR_TABLE,
  parameter logic                        USER_AT_RESET = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SPR_W-1:0]  sprNum,
  input  logic              msrWrData,
  input  ctrlStrobe_t       strobe,
  output logic              sprHit,
  output logic              sprSupv,
  output logic              sprRo,
  output logic              curUser,
  output logic              outValid,
  output logic [CODE_W-1:0] outCode
);
  logic [SPR_COUNT-1:0] hitVec;
  logic [SPR_COUNT-1:0] supvVec;
  logic [SPR_COUNT-1:0] roVec;
  logic                 pendingUser;

  for (genvar i = 0; i < SPR_COUNT; i++) begin : g_entry
    assign hitVec[i]  = SPR_TABLE[i].valid && (SPR_TABLE[i].num == sprNum);
    assign supvVec[i] = SPR_TABLE[i].supv;
    assign roVec[i]   = SPR_TABLE[i].ro;
  end

  assign sprHit  = |hitVec;
  assign sprSupv = |(hitVec & supvVec);
  assign sprRo   = |(hitVec & roVec);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid    <= 1'b0;
      outCode     <= '0;
      pendingUser <= USER_AT_RESET;
      curUser     <= USER_AT_RESET;
    end else begin
      outValid <= strobe.capture;
      outCode  <= strobe.capture ? strobe.code : '0;
      if (strobe.loadPending) pendingUser <= msrWrData;
      if (strobe.commitMode)  curUser     <= pendingUser;
    end
  end
endmodule

// File: rtl/instr_priv_checker.sv
module instr_priv_checker
  import ipc_pkg::*;
#(
  parameter int                        SPR_COUNT     = DEF_SPR_COUNT,
  parameter sprEntry_t [SPR_COUNT-1:0] SPR_TABLE     = DEF_SPR_TABLE,
  parameter logic                      USER_AT_RESET = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               issueValid,
  input  logic [CLASS_W-1:0] instrClass,
  input  logic [SPR_W-1:0]   sprNum,
  input  logic               trapCond,
  input  logic               msrWrData,
  output logic               resultValid,
  output logic [CODE_W-1:0]  resultCode,
  output logic               userMode
);
  ctrlStrobe_t strobe;
  logic        sprHit;
  logic        sprSupv;
  logic        sprRo;

  ipc_ctrl ctrl_i (
    .issueValid (issueValid),
    .instrClass (instrClass),
    .trapCond   (trapCond),
    .curUser    (userMode),
    .sprHit     (sprHit),
    .sprSupv    (sprSupv),
    .sprRo      (sprRo),
    .strobe     (strobe)
  );

  ipc_dpath #(
    .SPR_COUNT     (SPR_COUNT),
    .SPR_TABLE     (SPR_TABLE),
    .USER_AT_RESET (USER_AT_RESET)
  ) dpath_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sprNum    (sprNum),
    .msrWrData (msrWrData),
    .strobe    (strobe),
    .sprHit    (sprHit),
    .sprSupv   (sprSupv),
    .sprRo     (sprRo),
    .curUser   (userMode),
    .outValid  (resultValid),
    .outCode   (resultCode)
  );
endmodule

// File: rtl/ipc_chk.sv
module ipc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       issueValid,
  input logic [4:0] instrClass,
  input logic       trapCond,
  input logic       resultValid,
  input logic [2:0] resultCode,
  input logic       userMode
);
  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issueValid |=> resultValid);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !issueValid |=> !resultValid);

  // R2
  code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resultValid |-> (resultCode <= 3'd5));

  // R3
  user_fixed_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issueValid && userMode && instrClass >= 5'd1 && instrClass <= 5'd10)
      |=> (resultCode == 3'd2));

  // R7
  syscall_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issueValid && instrClass == 5'd14) |=> (resultCode == 3'd3));

  // R8
  trap_false_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issueValid && instrClass == 5'd15 && !trapCond) |=> (resultCode == 3'd0));

  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(issueValid && instrClass == 5'd16) |=> $stable(userMode));

  // R11
  upper_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issueValid && instrClass > 5'd16) |=> (resultCode == 3'd1));
endmodule

bind instr_priv_checker ipc_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .issueValid  (issueValid),
  .instrClass  (instrClass),
  .trapCond    (trapCond),
  .resultValid (resultValid),
  .resultCode  (resultCode),
  .userMode    (userMode)
);

// File: tb/instr_priv_checker_tb_top.sv
`timescale 1ns/1ps
module instr_priv_checker_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       issueValid = 1'b0;
  logic [4:0] instrClass = '0;
  logic [9:0] sprNum = '0;
  logic       trapCond = 1'b0;
  logic       msrWrData = 1'b0;
  logic       resultValid;
  logic [2:0] resultCode;
  logic       userMode;

  int vecCount  = 0;
  int missCount = 0;
  bit done      = 1'b0;

  always #2 clk = ~clk;

  instr_priv_checker dut_i (
    .clk(clk), .rst_n(rst_n), .issueValid(issueValid), .instrClass(instrClass),
    .sprNum(sprNum), .trapCond(trapCond), .msrWrData(msrWrData),
    .resultValid(resultValid), .resultCode(resultCode), .userMode(userMode)
  );

  // Register table taken from the requirements: number, valid, supervisor-only, read-only
  localparam int N = 11;
  int tNum [N] = '{1, 8, 9, 26, 272, 268, 269, 287, 1008, 1009, 1013};
  bit tVal [N] = '{1, 1, 1, 1, 1, 1, 1, 1, 1, 1, 0};
  bit tSup [N] = '{0, 0, 0, 1, 1, 0, 0, 1, 1, 1, 1};
  bit tRo  [N] = '{0, 0, 0, 0, 0, 1, 1, 1, 0, 1, 0};
  localparam int XN = 3;
  int extraNum [XN] = '{0, 500, 1023};

  function automatic int findEntry(int n);
    for (int i = 0; i < N; i++) if (tVal[i] && tNum[i] == n) return i;
    return -1;
  endfunction

  function automatic logic [2:0] expCode(int cls, int n, bit cond, bit user);
    int e = findEntry(n);
    if (cls > 16) return 3'd1;
    if (cls >= 11 && cls <= 13) begin
      if (e < 0) return 3'd1;
      if (tSup[e] && user) return 3'd2;
      if (cls == 11 && tRo[e]) return 3'd5;
      return 3'd0;
    end
    if (cls >= 1 && cls <= 10) return user ? 3'd2 : 3'd0;
    if (cls == 14) return 3'd3;
    if (cls == 15) return cond ? 3'd4 : 3'd0;
    return 3'd0;
  endfunction

  function automatic string tagFor(int cls, int n, bit user);
    int e = findEntry(n);
    if (cls > 16) return "R11";
    if (cls >= 11 && cls <= 13) begin
      if (e < 0) return "R4";
      if (tSup[e] && user) return "R5";
      if (cls == 11 && tRo[e]) return "R6";
      return "R5";
    end
    if (cls >= 1 && cls <= 10) return "R3";
    if (cls == 14) return "R7";
    if (cls == 15) return "R8";
    return "R2";
  endfunction

  task automatic checkBit(string tag, logic act, logic exp, string what);
    vecCount++;
    if (act !== exp) begin
      missCount++;
      $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  // Called at a falling edge; returns at a falling edge.
  task automatic applyVec(int cls, int n, bit cond, bit wr, logic [2:0] exp, string tag);
    issueValid = 1'b1;
    instrClass = cls[4:0];
    sprNum     = n[9:0];
    trapCond   = cond;
    msrWrData  = wr;
    @(negedge clk);
    vecCount++;
    if (resultValid !== 1'b1 || resultCode !== exp) begin
      missCount++;
      $display("FAIL %s class=%0d num=%0d cond=%0b: actual valid=%0b code=%0d expected valid=1 code=%0d",
               tag, cls, n, cond, resultValid, resultCode, 1'b1, exp);
    end
    issueValid = 1'b0;
    @(negedge clk);
    checkBit("R2", resultValid, 1'b0, "idle valid");
  endtask

  task automatic sweep(bit user);
    for (int c = 0; c < 32; c++) begin
      for (int k = 0; k < N + XN; k++) begin
        int n = (k < N) ? tNum[k] : extraNum[k - N];
        for (int t = 0; t < 2; t++) begin
          applyVec(c, n, t[0], user, expCode(c, n, t[0], user), tagFor(c, n, user));
        end
      end
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    checkBit("R1", resultValid, 1'b0, "reset valid");
    checkBit("R1", resultCode == 3'd0, 1'b1, "reset code zero");
    checkBit("R1", userMode, 1'b0, "reset mode");
    rst_n = 1'b1;
    @(negedge clk);
    checkBit("R1", resultValid, 1'b0, "post-reset valid");

    sweep(1'b0);

    // R9: pending write does not act before synchronisation
    applyVec(3, 0, 0, 1'b1, 3'd0, "R9");
    checkBit("R9", userMode, 1'b0, "mode before sync");
    applyVec(2, 0, 0, 1'b1, 3'd0, "R9");
    applyVec(16, 0, 0, 1'b1, 3'd0, "R9");
    checkBit("R9", userMode, 1'b1, "mode after sync");
    applyVec(2, 0, 0, 1'b1, 3'd2, "R9");

    sweep(1'b1);

    // R10: user write to machine state faults and leaves pending value alone
    applyVec(3, 0, 0, 1'b0, 3'd2, "R10");
    applyVec(16, 0, 0, 1'b0, 3'd0, "R10");
    checkBit("R10", userMode, 1'b1, "mode after faulted write");
    applyVec(9, 0, 0, 1'b0, 3'd2, "R10");

    done = 1'b1;
    finishRun();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      missCount++;
      $display("FAIL R2 watchdog: actual=timeout expected=completion");
      finishRun();
    end
  end
endmodule